// File: doc/BRIEF.md
# Thread Context CAM Matcher

This block sits beside one hardware thread and decides whether an incoming notification is aimed at that thread. It holds four context words, one per privilege ring (physical, hypervisor pool, OS and user). When a request arrives, it compares the request's target against those words and returns either no match or the ring that matched. A request carries a format bit, a target block and index, an ignore flag and a logical server number.

The block also derives the thread's own hardware CAM line from the chip block id and the processor thread id. The physical ring is matched against that derived line, not against a stored field. Matching on the lower bits of the target only (ignore mode) is not handled: such a request is answered with an unsupported flag and no match. A simple load port writes the context words. Each word arrives in big-endian memory byte order and is kept that way.

Top module: `tcam_matcher`

## Requirements
- R1: While and after reset, res_valid, res_match and res_unsup are 0 and res_ring is 0.
- R2: hw_cam equals {blk_id, idx}, where idx is 19 bits: bits 18:8 are 0, bit 7 is 1 and bits 6:0 are thread_id[6:0].
- R3: A request with req_fmt=0 and req_ign=1 returns res_unsup=1, res_match=0 and res_ring=0, whatever the context words hold.
- R4: With req_fmt=0 and req_ign=0, the rings are tried in the order physical, pool, OS, and the first hit is reported. The ring codes are physical=3, pool=2, OS=1 and user=0. With no hit, res_match=0 and res_ring=0.
- R5: The physical ring (word 3) hits when its valid bit (logical bit 31) is 1 and the target CAM {req_blk, req_idx} equals hw_cam.
- R6: The pool ring (word 2) and the OS ring (word 1) each hit when their valid bit (logical bit 31) is 1 and their logical bits 22:0 equal the target CAM {req_blk, req_idx}.
- R7: With req_fmt=1, only the user ring can hit, giving code 0. It needs four things: the OS word valid, the OS CAM equal to the target, the user word (word 0) valid at logical bit 31, and user logical bits 7:0 equal to req_ls.
- R8: A context word is loaded in big-endian memory order. ctx_wdata bits 7:0 become logical bits 31:24, bits 15:8 become 23:16, bits 23:16 become 15:8 and bits 31:24 become 7:0.
- R9: A result appears one cycle after the req_valid cycle, with res_valid high for exactly that cycle. res_match, res_ring and res_unsup hold their values until the next request.
- R10: A request in the same cycle as a load to the same ring is evaluated against the word held before that load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| blk_id | input | 4 | Chip block id of this thread |
| thread_id | input | 16 | Processor thread id (low 7 bits used) |
| ctx_we | input | 1 | Context word load strobe |
| ctx_sel | input | 2 | Ring code of the word to load |
| ctx_wdata | input | 32 | Context word in big-endian memory byte order |
| req_valid | input | 1 | Request strobe |
| req_fmt | input | 1 | Request format (0 = thread rings, 1 = user ring) |
| req_ign | input | 1 | Ignore-mode flag |
| req_blk | input | 4 | Target block |
| req_idx | input | 19 | Target index |
| req_ls | input | 8 | Logical server number |
| res_valid | output | 1 | Result strobe |
| res_match | output | 1 | A ring matched |
| res_ring | output | 2 | Matching ring code |
| res_unsup | output | 1 | Request used unsupported ignore mode |
| hw_cam | output | 23 | Derived hardware CAM line |

## Verification
The hardest case to reach is several rings hitting on the same request, because priority only shows when more than one ring matches. For the physical ring to take part, the target has to equal the derived hardware line. The user ring depends on the OS CAM and on the logical server field at the same time. The random stimulus therefore draws targets and stored CAM fields from a small shared pool that includes hw_cam, so overlaps happen often. Directed cases force all rings valid and identical, and also cover a load and a request in the same cycle.

// File: rtl/tcam_pkg.sv
// Shared widths, ring codes and field positions for the thread context matcher.
// Assumes a 32-bit context word with the valid flag in the top logical bit.
package tcam_pkg;
    parameter int BLK_W    = 4;
    parameter int IDX_W    = 19;
    parameter int TID_IN_W = 16;
    parameter int TID_W    = 7;
    parameter int LS_W     = 8;
    parameter int WORD_W   = 32;
    parameter int NRING    = 4;

    localparam int CAM_W     = BLK_W + IDX_W;
    localparam int VALID_BIT = WORD_W - 1;
    localparam int RSEL_W    = $clog2(NRING);

    typedef enum logic [1:0] {
        RING_USER = 2'd0,
        RING_OS   = 2'd1,
        RING_POOL = 2'd2,
        RING_PHYS = 2'd3
    } ring_e;
endpackage

// File: rtl/tcam_ctx_store.sv
// Holds the per-ring context words as loaded, in big-endian memory order,
// and presents each one in logical (host) bit order.
// Assumes the word width is a whole number of bytes.
module tcam_ctx_store
    import tcam_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int NR = NRING
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [$clog2(NR)-1:0]  sel,
    input  logic [W-1:0]           wdata,
    output logic [NR-1:0][W-1:0]   words
);
    localparam int NBYTE = W / 8;

    logic [NR-1:0][W-1:0] raw_q;

    // Load one raw word per write strobe, clear all on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= '0;
        end else if (we) begin
            raw_q[sel] <= wdata;
        end
    end

    // Reorder bytes so the first memory byte lands in the top logical byte.
    for (genvar r = 0; r < NR; r++) begin : g_ring
        for (genvar b = 0; b < NBYTE; b++) begin : g_byte
            assign words[r][W-1-8*b -: 8] = raw_q[r][8*b +: 8];
        end
    end
endmodule

// File: rtl/tcam_hw_line.sv
// Builds the thread's own hardware CAM line: the block id above an index
// that has a marker bit just above the low thread id bits.
// Assumes the index is wider than the thread id field plus the marker.
module tcam_hw_line
    import tcam_pkg::*;
#(
    parameter int BW  = BLK_W,
    parameter int IW  = IDX_W,
    parameter int TIW = TID_IN_W,
    parameter int TW  = TID_W
) (
    input  logic [BW-1:0]    blk_id,
    input  logic [TIW-1:0]   thread_id,
    output logic [BW+IW-1:0] cam
);
    localparam int PAD_W = IW - TW - 1;

    logic [IW-1:0]      idx;
    logic [TIW-TW-1:0]  unused_tid_hi;

    // Assemble the index: zero pad, marker bit, low thread id bits.
    always_comb begin
        idx = {{PAD_W{1'b0}}, 1'b1, thread_id[TW-1:0]};
        cam = {blk_id, idx};
    end

    assign unused_tid_hi = thread_id[TIW-1:TW];
endmodule

// File: rtl/tcam_ring_eval.sv
// Combinational ring match: evaluates each ring's hit and applies the fixed
// priority physical > pool > OS for format 0, or the user rule for format 1.
// Assumes logical words with valid at the top bit, CAM and server in low bits.
module tcam_ring_eval
    import tcam_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int CW  = CAM_W,
    parameter int LW  = LS_W
) (
    input  logic [NRING-1:0][W-1:0] words,
    input  logic [CW-1:0]           hw_cam,
    input  logic [CW-1:0]           tgt_cam,
    input  logic                    fmt,
    input  logic                    ign,
    input  logic [LW-1:0]           ls,
    output logic                    hit,
    output logic [1:0]              ring,
    output logic                    unsup
);
    logic [NRING-1:0] cam_hit;
    logic             phys_hit;
    logic             user_hit;
    logic [W-CW-2:0]  unused_mid_cam [NRING];
    logic [W-LW-2:0]  unused_mid_ls;

    // Physical ring compares against the derived hardware line.
    assign phys_hit = words[RING_PHYS][VALID_BIT] && (tgt_cam == hw_cam);

    // Pool and OS rings compare against their stored CAM fields.
    for (genvar r = 0; r < NRING; r++) begin : g_cam
        if (r == int'(RING_POOL) || r == int'(RING_OS)) begin : g_cmp
            assign cam_hit[r] = words[r][VALID_BIT] && (words[r][CW-1:0] == tgt_cam);
        end else begin : g_none
            assign cam_hit[r] = 1'b0;
        end
        assign unused_mid_cam[r] = words[r][W-2:CW];
    end

    // User ring needs an OS hit plus a valid user word with equal server number.
    assign user_hit = cam_hit[RING_OS] && words[RING_USER][VALID_BIT]
                   && (words[RING_USER][LW-1:0] == ls);
    assign unused_mid_ls = words[RING_USER][W-2:LW];

    // Select the outcome by format, ignore mode and ring priority.
    always_comb begin
        hit   = 1'b0;
        ring  = RING_USER;
        unsup = 1'b0;
        if (fmt) begin
            if (user_hit) begin
                hit  = 1'b1;
                ring = RING_USER;
            end
        end else if (ign) begin
            unsup = 1'b1;
        end else if (phys_hit) begin
            hit  = 1'b1;
            ring = RING_PHYS;
        end else if (cam_hit[RING_POOL]) begin
            hit  = 1'b1;
            ring = RING_POOL;
        end else if (cam_hit[RING_OS]) begin
            hit  = 1'b1;
            ring = RING_OS;
        end
    end
endmodule

// File: rtl/tcam_matcher.sv
// Top of the thread context CAM matcher: context store, hardware line build,
// ring evaluation and a one-cycle result register.
// Assumes requests and context loads are single-cycle strobes on clk.
module tcam_matcher
    import tcam_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BLK_W-1:0]    blk_id,
    input  logic [TID_IN_W-1:0] thread_id,
    input  logic                ctx_we,
    input  logic [RSEL_W-1:0]   ctx_sel,
    input  logic [WORD_W-1:0]   ctx_wdata,
    input  logic                req_valid,
    input  logic                req_fmt,
    input  logic                req_ign,
    input  logic [BLK_W-1:0]    req_blk,
    input  logic [IDX_W-1:0]    req_idx,
    input  logic [LS_W-1:0]     req_ls,
    output logic                res_valid,
    output logic                res_match,
    output logic [1:0]          res_ring,
    output logic                res_unsup,
    output logic [CAM_W-1:0]    hw_cam
);
    logic [NRING-1:0][WORD_W-1:0] words;
    logic                         ev_hit;
    logic [1:0]                   ev_ring;
    logic                         ev_unsup;

    tcam_ctx_store #(.W(WORD_W), .NR(NRING)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctx_we),
        .sel   (ctx_sel),
        .wdata (ctx_wdata),
        .words (words)
    );

    tcam_hw_line #(.BW(BLK_W), .IW(IDX_W), .TIW(TID_IN_W), .TW(TID_W)) u_line (
        .blk_id    (blk_id),
        .thread_id (thread_id),
        .cam       (hw_cam)
    );

    tcam_ring_eval #(.W(WORD_W), .CW(CAM_W), .LW(LS_W)) u_eval (
        .words   (words),
        .hw_cam  (hw_cam),
        .tgt_cam ({req_blk, req_idx}),
        .fmt     (req_fmt),
        .ign     (req_ign),
        .ls      (req_ls),
        .hit     (ev_hit),
        .ring    (ev_ring),
        .unsup   (ev_unsup)
    );

    // Register the outcome of each request; hold it between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_match <= 1'b0;
            res_ring  <= 2'd0;
            res_unsup <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_match <= ev_hit;
                res_ring  <= ev_ring;
                res_unsup <= ev_unsup;
            end
        end
    end
endmodule

// File: rtl/tcam_matcher_checker.sv
// Protocol checks on the matcher ports, attached by bind.
module tcam_matcher_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_fmt,
    input logic       req_ign,
    input logic       res_valid,
    input logic       res_match,
    input logic [1:0] res_ring,
    input logic       res_unsup
);
    p_unsup_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fmt && req_ign) |=> (res_unsup && !res_match && res_ring == 2'd0));

    p_fmt0_ring_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_fmt && !req_ign) |=> (!res_unsup && (!res_match || res_ring != 2'd0)));

    p_fmt1_user_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fmt) |=> (!res_unsup && res_ring == 2'd0));

    p_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && $stable(res_match) && $stable(res_ring) && $stable(res_unsup)));

    p_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_match && res_unsup));
endmodule

bind tcam_matcher tcam_matcher_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_fmt   (req_fmt),
    .req_ign   (req_ign),
    .res_valid (res_valid),
    .res_match (res_match),
    .res_ring  (res_ring),
    .res_unsup (res_unsup)
);

// File: tb/tcam_matcher_bench.sv
module tcam_matcher_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  blk_id = 4'h5;
    logic [15:0] thread_id = 16'hA3C9;
    logic        ctx_we = 1'b0;
    logic [1:0]  ctx_sel = '0;
    logic [31:0] ctx_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_fmt = 1'b0;
    logic        req_ign = 1'b0;
    logic [3:0]  req_blk = '0;
    logic [18:0] req_idx = '0;
    logic [7:0]  req_ls = '0;
    logic        res_valid, res_match, res_unsup;
    logic [1:0]  res_ring;
    logic [22:0] hw_cam;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] shadow [4];

    always #2 clk = ~clk;

    tcam_matcher u_tcam_matcher (.*);

    function automatic logic [31:0] be(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [22:0] exp_hw(input logic [3:0] b, input logic [15:0] t);
        return {b, 11'd0, 1'b1, t[6:0]};
    endfunction

    // Expected {unsup, match, ring} from logical words
    function automatic logic [3:0] exp_res(input logic f, input logic ig,
                                           input logic [22:0] tc, input logic [7:0] l);
        logic [31:0] u, o, p, h;
        u = shadow[0]; o = shadow[1]; p = shadow[2]; h = shadow[3];
        if (f) begin
            if (o[31] && o[22:0] == tc && u[31] && u[7:0] == l) return 4'b0100;
            return 4'b0000;
        end
        if (ig) return 4'b1000;
        if (h[31] && tc == exp_hw(blk_id, thread_id)) return 4'b0111;
        if (p[31] && p[22:0] == tc) return 4'b0110;
        if (o[31] && o[22:0] == tc) return 4'b0101;
        return 4'b0000;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Load a logical word into a ring (sent in big-endian memory order)
    task automatic load(input logic [1:0] r, input logic [31:0] logical);
        @(negedge clk);
        ctx_we = 1'b1; ctx_sel = r; ctx_wdata = be(logical);
        @(posedge clk); #1;
        ctx_we = 1'b0;
        shadow[r] = logical;
    endtask

    task automatic request(input string tag, input logic f, input logic ig,
                           input logic [22:0] tc, input logic [7:0] l);
        logic [3:0] e;
        @(negedge clk);
        req_valid = 1'b1; req_fmt = f; req_ign = ig;
        {req_blk, req_idx} = tc; req_ls = l;
        e = exp_res(f, ig, tc, l);
        @(posedge clk); #1;
        req_valid = 1'b0;
        check({tag, " valid"}, {31'd0, res_valid}, 32'd1);
        check(tag, {28'd0, res_unsup, res_match, res_ring}, {28'd0, e});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [22:0] hw, camA, camB, pool [4];
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 4; i++) shadow[i] = '0;
        repeat (3) @(posedge clk); #1;
        check("R1 reset", {28'd0, res_valid, res_match, res_unsup, 1'b0}, 32'd0);
        check("R1 reset ring", {30'd0, res_ring}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 after reset", {29'd0, res_valid, res_match, res_unsup}, 32'd0);

        hw = exp_hw(blk_id, thread_id);
        check("R2 hw line", {9'd0, hw_cam}, {9'd0, hw});
        check("R2 hw line value", {9'd0, hw_cam}, {9'd0, 23'h2800C9});
        camA = 23'h1_2345; camB = 23'h7_0F0F;

        // R5 physical only
        load(2'd3, 32'h8000_0000);
        request("R5 phys hit", 1'b0, 1'b0, hw, 8'd0);
        check("R5 phys code", {30'd0, res_ring}, 32'd3);
        request("R5 phys miss", 1'b0, 1'b0, camA, 8'd0);
        // R6 pool and os
        load(2'd2, {1'b1, 8'd0, camA});
        load(2'd1, {1'b1, 8'd0, camB});
        request("R6 pool", 1'b0, 1'b0, camA, 8'd0);
        check("R6 pool code", {30'd0, res_ring}, 32'd2);
        request("R6 os", 1'b0, 1'b0, camB, 8'd0);
        check("R6 os code", {30'd0, res_ring}, 32'd1);
        // R4 priority: all three rings hold the hw line
        load(2'd2, {1'b1, 8'd0, hw});
        load(2'd1, {1'b1, 8'd0, hw});
        request("R4 prio phys", 1'b0, 1'b0, hw, 8'd0);
        load(2'd3, 32'h0000_0000);
        request("R4 prio pool", 1'b0, 1'b0, hw, 8'd0);
        check("R4 pool code", {30'd0, res_ring}, 32'd2);
        load(2'd2, {1'b0, 8'd0, hw});
        request("R4 prio os", 1'b0, 1'b0, hw, 8'd0);
        // R3 ignore mode with matching rings
        request("R3 ignore", 1'b0, 1'b1, hw, 8'd0);
        check("R3 unsup flag", {31'd0, res_unsup}, 32'd1);
        // R7 user ring
        load(2'd0, {1'b1, 23'd0, 8'h5A});
        request("R7 user hit", 1'b1, 1'b0, hw, 8'h5A);
        check("R7 user match", {31'd0, res_match}, 32'd1);
        request("R7 ls miss", 1'b1, 1'b0, hw, 8'h5B);
        request("R7 os cam miss", 1'b1, 1'b0, camA, 8'h5A);
        load(2'd1, {1'b0, 8'd0, hw});
        request("R7 os invalid", 1'b1, 1'b0, hw, 8'h5A);
        check("R7 no match", {31'd0, res_match}, 32'd0);
        // R8 byte order: a word sent in logical order must not match
        @(negedge clk);
        ctx_we = 1'b1; ctx_sel = 2'd2; ctx_wdata = {1'b1, 8'd0, camA};
        @(posedge clk); #1; ctx_we = 1'b0;
        shadow[2] = be({1'b1, 8'd0, camA});
        request("R8 swapped miss", 1'b0, 1'b0, camA, 8'd0);
        check("R8 no match", {31'd0, res_match}, 32'd0);
        load(2'd2, {1'b1, 8'd0, camA});
        request("R8 ordered hit", 1'b0, 1'b0, camA, 8'd0);
        // R9 hold between requests
        repeat (3) @(posedge clk); #1;
        check("R9 pulse ends", {31'd0, res_valid}, 32'd0);
        check("R9 hold", {29'd0, res_unsup, res_ring}, 32'd2);
        // R10 same-cycle load and request: old word still used
        @(negedge clk);
        ctx_we = 1'b1; ctx_sel = 2'd2; ctx_wdata = be(32'h0);
        req_valid = 1'b1; req_fmt = 1'b0; req_ign = 1'b0;
        {req_blk, req_idx} = camA;
        @(posedge clk); #1;
        ctx_we = 1'b0; req_valid = 1'b0; shadow[2] = 32'h0;
        check("R10 old word", {30'd0, res_match, res_ring[1]}, 32'd3);
        request("R10 new word", 1'b0, 1'b0, camA, 8'd0);

        // Random mix from a small shared pool so rings overlap
        pool[0] = hw; pool[1] = camA; pool[2] = camB; pool[3] = 23'h00_0001;
        for (int it = 0; it < 400; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 4) begin
                logic [1:0] r;
                logic [31:0] w;
                r = 2'($urandom_range(0, 3));
                w = {1'($urandom_range(0, 1)), 8'($urandom), pool[$urandom_range(0, 3)]};
                if (r == 2'd0) w[7:0] = 8'($urandom_range(0, 2));
                load(r, w);
            end else begin
                logic f, ig;
                f = 1'($urandom_range(0, 1));
                ig = ($urandom_range(0, 7) == 0);
                request(f ? "R7 random" : (ig ? "R3 random" : "R4 random"),
                        f, ig, pool[$urandom_range(0, 3)], 8'($urandom_range(0, 2)));
            end
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule